// File: doc/BRIEF.md
# Memory Check-Error Policy Controller

This block collects check-error events raised by on-chip memories and turns them into sticky status flags and system responses. Parity events arrive from a set of general-purpose RAM banks, a high-speed RAM and a cache RAM. Each of two ECC-protected regions reports two kinds of event: single-bit errors, which the region has already corrected, and double-bit errors, which it can only detect. Every event is a one-cycle input pulse. The memories and the ECC datapath are outside this block.

Software reaches the block through a simple register port with three registers. A write to the key register with the unlock key opens the configuration register for writes. Any other value written there closes it again. The configuration register holds a two-bit ECC reporting mode for each ECC region. It also holds three response selects: one shared by the parity banks and the high-speed RAM, and one for each ECC region. The status register holds one flag per event source. Writing a 1 to a flag clears it. To return the block to its initial state, software writes zero to the configuration and all ones to the status register.

An enabled error gives one of two responses. The first is a level non-maskable interrupt request, which stays high while a responding flag remains set. The second is a one-cycle system reset request. The register port is a plain control interface. It has no back-pressure: a write takes effect on the clock edge where `reg_wr_en` is high, and read data follows `reg_addr` combinationally.

Top module: `mem_err_policy_ctrl`

## Requirements
- R1: After reset the block is locked, the configuration and all status flags read 0, and `nmi_o` and `rst_req_o` are low.
- R2: Writing exactly 0x0077 to the key register (address 0) unlocks the block. Writing any other 16-bit value relocks it. Address 0 reads back the lock state in bit 0 (1 = unlocked).
- R3: A write to the configuration register (address 1) updates it only while the block is unlocked. Otherwise the write is ignored. Its field layout is: bits [1:0] ECC region A mode, bits [3:2] ECC region B mode, bit 4 parity response select, bit 5 region A select, bit 6 region B select.
- R4: A parity event sets its flag in the status register (address 2). Bank 1, bank 2 and bank 3 use bits 0 to 2, the high-speed RAM uses bit 3, and the cache RAM uses bit 8. Bank and high-speed RAM events respond through the parity select. Cache events set their flag only.
- R5: In ECC mode 0 neither single-bit nor double-bit events of that region set a flag or cause a response.
- R6: A single-bit ECC event behaves according to the region's mode. In mode 1 it sets no flag and gives no response. In mode 2 it sets its flag (A: bit 4, B: bit 6) but gives no response. In mode 3 it sets the flag and responds.
- R7: In modes 1, 2 and 3, a double-bit ECC event sets its flag (A: bit 5, B: bit 7) and responds.
- R8: A select value of 0 routes the response to `nmi_o`. A value of 1 raises `rst_req_o` for exactly one cycle, in the cycle after the event.
- R9: `nmi_o` stays high while any flag whose response is enabled and routed to NMI is set, and falls once all such flags are cleared. A single-bit flag counts only while its region is in mode 3.
- R10: Writing 1 to a status bit clears it. Writing 0 leaves it unchanged.
- R11: When an event and a clearing write hit the same flag in the same cycle, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data for `reg_addr` |
| bank_par_evt | input | 3 | Parity error pulses from the general RAM banks |
| hs_par_evt | input | 1 | Parity error pulse from the high-speed RAM |
| cache_par_evt | input | 1 | Parity error pulse from the cache RAM |
| ecc_sbe_evt | input | 2 | Single-bit ECC error pulses, bit 0 region A, bit 1 region B |
| ecc_dbe_evt | input | 2 | Double-bit ECC error pulses, bit 0 region A, bit 1 region B |
| nmi_o | output | 1 | Level non-maskable interrupt request |
| rst_req_o | output | 1 | One-cycle system reset request |

## Verification
A new error event and a write-one-to-clear to the status register can land on the same flag in the same clock cycle. The bench first sets a bank flag. It then drives that bank's event pulse together with a status write that has the flag's bit set. The flag must still read 1 afterwards. The same write without the event must clear the flag. This separates a design that merges the set and clear terms correctly from one that lets the clear win.

// File: rtl/mep_pkg.sv
package mep_pkg;

  typedef enum logic [1:0] {
    ADDR_KEY  = 2'd0,
    ADDR_CFG  = 2'd1,
    ADDR_STAT = 2'd2,
    ADDR_NONE = 2'd3
  } reg_addr_e;

  typedef enum logic [1:0] {
    ECC_OFF    = 2'd0,
    ECC_SILENT = 2'd1,
    ECC_FLAG   = 2'd2,
    ECC_FULL   = 2'd3
  } ecc_mode_e;

  localparam int unsigned NUM_ECC = 2;
  localparam int unsigned CFG_W   = 7;

  // Packed MSB first: bit 6 sel_b ... bits [1:0] mode_a
  typedef struct packed {
    logic      sel_b;
    logic      sel_a;
    logic      sel_par;
    ecc_mode_e mode_b;
    ecc_mode_e mode_a;
  } cfg_t;

endpackage

// File: rtl/mep_key_guard.sv
module mep_key_guard #(
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 16'h0077
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              key_wr,
  input  logic [DATA_W-1:0] key_data,
  output logic              unlocked
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      unlocked <= 1'b0;
    end else if (key_wr) begin
      unlocked <= (key_data == UNLOCK_KEY);
    end
  end

endmodule

// File: rtl/mep_cfg_reg.sv
module mep_cfg_reg
  import mep_pkg::*;
#(
  parameter int unsigned DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic              unlocked,
  input  logic [DATA_W-1:0] cfg_data,
  output cfg_t              cfg
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cfg <= '0;
    end else if (cfg_wr && unlocked) begin
      cfg <= cfg_t'(cfg_data[CFG_W-1:0]);
    end
  end

endmodule

// File: rtl/mep_event_qual.sv
module mep_event_qual
  import mep_pkg::*;
#(
  parameter int unsigned NBANK = 3,
  localparam int unsigned NPAR = NBANK + 1,
  localparam int unsigned SW   = NBANK + 6
) (
  input  cfg_t               cfg,
  input  logic [NPAR-1:0]    par_evt,
  input  logic               cache_evt,
  input  logic [NUM_ECC-1:0] sbe_evt,
  input  logic [NUM_ECC-1:0] dbe_evt,
  output logic [SW-1:0]      set_vec,
  output logic [SW-1:0]      nmi_mask,
  output logic               rst_hit
);

  ecc_mode_e          mode [NUM_ECC];
  logic [NUM_ECC-1:0] sel;
  logic [NUM_ECC-1:0] sbe_set, sbe_resp, dbe_set, sbe_arm;

  always_comb begin
    mode[0] = cfg.mode_a;
    mode[1] = cfg.mode_b;
    sel     = {cfg.sel_b, cfg.sel_a};
  end

  for (genvar r = 0; r < NUM_ECC; r++) begin : g_ecc
    localparam int unsigned SBE_POS = NPAR + 2*r;
    localparam int unsigned DBE_POS = NPAR + 2*r + 1;
    always_comb begin
      sbe_set[r]  = sbe_evt[r] && (mode[r] == ECC_FLAG || mode[r] == ECC_FULL);
      sbe_arm[r]  = (mode[r] == ECC_FULL);
      sbe_resp[r] = sbe_evt[r] && sbe_arm[r];
      dbe_set[r]  = dbe_evt[r] && (mode[r] != ECC_OFF);
    end
    assign set_vec[SBE_POS]  = sbe_set[r];
    assign set_vec[DBE_POS]  = dbe_set[r];
    assign nmi_mask[SBE_POS] = sbe_arm[r] && !sel[r];
    assign nmi_mask[DBE_POS] = !sel[r];
  end

  assign set_vec[NPAR-1:0]  = par_evt;
  assign set_vec[SW-1]      = cache_evt;
  assign nmi_mask[NPAR-1:0] = {NPAR{!cfg.sel_par}};
  assign nmi_mask[SW-1]     = 1'b0;

  always_comb begin
    rst_hit = (|par_evt) && cfg.sel_par;
    for (int r = 0; r < NUM_ECC; r++) begin
      if ((sbe_resp[r] || dbe_set[r]) && sel[r]) rst_hit = 1'b1;
    end
  end

endmodule

// File: rtl/mep_status_reg.sv
module mep_status_reg #(
  parameter int unsigned SW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [SW-1:0] set_vec,
  input  logic [SW-1:0] clr_vec,
  output logic [SW-1:0] flags
);

  // set term applied after clear: a same-cycle event keeps the flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags <= '0;
    end else begin
      flags <= (flags & ~clr_vec) | set_vec;
    end
  end

endmodule

// File: rtl/mem_err_policy_ctrl.sv
module mem_err_policy_ctrl
  import mep_pkg::*;
#(
  parameter int unsigned NBANK  = 3,
  parameter int unsigned DATA_W = 16,
  parameter logic [DATA_W-1:0] UNLOCK_KEY = 16'h0077
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                reg_wr_en,
  input  logic [1:0]          reg_addr,
  input  logic [DATA_W-1:0]   reg_wdata,
  output logic [DATA_W-1:0]   reg_rdata,
  input  logic [NBANK-1:0]    bank_par_evt,
  input  logic                hs_par_evt,
  input  logic                cache_par_evt,
  input  logic [NUM_ECC-1:0]  ecc_sbe_evt,
  input  logic [NUM_ECC-1:0]  ecc_dbe_evt,
  output logic                nmi_o,
  output logic                rst_req_o
);

  localparam int unsigned NPAR = NBANK + 1;
  localparam int unsigned SW   = NBANK + 6;

  logic          unlocked_q;
  cfg_t          cfg_q;
  logic [SW-1:0] status_q, set_vec, nmi_mask, clr_vec;
  logic          rst_hit, rst_q;
  logic          key_wr, cfg_wr, stat_wr;

  assign key_wr  = reg_wr_en && (reg_addr == ADDR_KEY);
  assign cfg_wr  = reg_wr_en && (reg_addr == ADDR_CFG);
  assign stat_wr = reg_wr_en && (reg_addr == ADDR_STAT);
  assign clr_vec = stat_wr ? reg_wdata[SW-1:0] : '0;

  mep_key_guard #(.DATA_W(DATA_W), .UNLOCK_KEY(UNLOCK_KEY)) u_key (
    .clk(clk), .rst_n(rst_n), .key_wr(key_wr), .key_data(reg_wdata),
    .unlocked(unlocked_q)
  );

  mep_cfg_reg #(.DATA_W(DATA_W)) u_cfg (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .unlocked(unlocked_q),
    .cfg_data(reg_wdata), .cfg(cfg_q)
  );

  mep_event_qual #(.NBANK(NBANK)) u_qual (
    .cfg(cfg_q), .par_evt({hs_par_evt, bank_par_evt}), .cache_evt(cache_par_evt),
    .sbe_evt(ecc_sbe_evt), .dbe_evt(ecc_dbe_evt),
    .set_vec(set_vec), .nmi_mask(nmi_mask), .rst_hit(rst_hit)
  );

  mep_status_reg #(.SW(SW)) u_stat (
    .clk(clk), .rst_n(rst_n), .set_vec(set_vec), .clr_vec(clr_vec),
    .flags(status_q)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_q <= 1'b0;
    else        rst_q <= rst_hit;
  end

  assign rst_req_o = rst_q;
  assign nmi_o     = |(status_q & nmi_mask);

  always_comb begin
    reg_rdata = '0;
    case (reg_addr)
      ADDR_KEY:  reg_rdata[0]       = unlocked_q;
      ADDR_CFG:  reg_rdata[CFG_W-1:0] = cfg_q;
      ADDR_STAT: reg_rdata[SW-1:0]  = status_q;
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/mep_checker.sv
module mep_checker
  import mep_pkg::*;
#(
  parameter int unsigned NBANK  = 3,
  parameter int unsigned DATA_W = 16,
  localparam int unsigned NPAR  = NBANK + 1,
  localparam int unsigned SW    = NBANK + 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic               reg_wr_en,
  input logic [1:0]         reg_addr,
  input logic [DATA_W-1:0]  reg_wdata,
  input logic [NBANK-1:0]   bank_par_evt,
  input logic [NUM_ECC-1:0] ecc_dbe_evt,
  input logic               nmi_o,
  input logic               unlocked_q,
  input cfg_t               cfg_q,
  input logic [SW-1:0]      status_q
);

  localparam int unsigned A_SBE = NPAR;
  localparam int unsigned A_DBE = NPAR + 1;

  AST_LOCKED_CFG_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !unlocked_q |=> $stable(cfg_q)); // R3

  AST_BANK_EVT_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    bank_par_evt[0] |=> status_q[0]); // R4

  AST_SBE_QUIET_LOW_MODE: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode_a inside {ECC_OFF, ECC_SILENT} && !status_q[A_SBE]) |=> !status_q[A_SBE]); // R6

  AST_DBE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_q.mode_a != ECC_OFF && ecc_dbe_evt[0]) |=> status_q[A_DBE]); // R7

  AST_NMI_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (nmi_o && !reg_wr_en) |=> nmi_o); // R9

  AST_EVENT_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == ADDR_STAT && reg_wdata[1] && bank_par_evt[1]) |=> status_q[1]); // R11

  AST_ZERO_WRITE_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr_en && reg_addr == ADDR_STAT && !reg_wdata[2] && status_q[2]) |=> status_q[2]); // R10

endmodule

bind mem_err_policy_ctrl mep_checker #(.NBANK(NBANK), .DATA_W(DATA_W)) u_mep_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
  .reg_wdata(reg_wdata), .bank_par_evt(bank_par_evt), .ecc_dbe_evt(ecc_dbe_evt),
  .nmi_o(nmi_o), .unlocked_q(unlocked_q), .cfg_q(cfg_q), .status_q(status_q)
);

// File: tb/test_mem_err_policy_ctrl.sv
module test_mem_err_policy_ctrl;
  localparam int PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr_en = 1'b0;
  logic [1:0]  reg_addr = 2'd0;
  logic [15:0] reg_wdata = 16'd0;
  logic [15:0] reg_rdata;
  logic [2:0]  bank_par_evt = '0;
  logic        hs_par_evt = 1'b0;
  logic        cache_par_evt = 1'b0;
  logic [1:0]  ecc_sbe_evt = '0;
  logic [1:0]  ecc_dbe_evt = '0;
  logic        nmi_o, rst_req_o;

  int n_vec = 0;
  int n_bad = 0;

  always #(PERIOD/2) clk = ~clk;

  mem_err_policy_ctrl i_mem_err_policy_ctrl (
    .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bank_par_evt(bank_par_evt),
    .hs_par_evt(hs_par_evt), .cache_par_evt(cache_par_evt),
    .ecc_sbe_evt(ecc_sbe_evt), .ecc_dbe_evt(ecc_dbe_evt),
    .nmi_o(nmi_o), .rst_req_o(rst_req_o)
  );

  task automatic check(input string tag, input int got, input int exp);
    n_vec++;
    if (got != exp) begin
      n_bad++;
      $display("FAIL %s got=0x%0h exp=0x%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d, input logic [8:0] ev = '0);
    @(negedge clk);
    reg_wr_en = 1'b1; reg_addr = a; reg_wdata = d;
    {cache_par_evt, ecc_dbe_evt[1], ecc_sbe_evt[1], ecc_dbe_evt[0], ecc_sbe_evt[0],
     hs_par_evt, bank_par_evt} = ev;
    @(negedge clk);
    reg_wr_en = 1'b0;
    {cache_par_evt, ecc_dbe_evt[1], ecc_sbe_evt[1], ecc_dbe_evt[0], ecc_sbe_evt[0],
     hs_par_evt, bank_par_evt} = '0;
  endtask

  task automatic rd_check(input logic [1:0] a, input int exp, input string tag);
    @(negedge clk);
    reg_addr = a;
    #1 check(tag, int'(reg_rdata), exp);
  endtask

  // event vector: [2:0] banks, 3 hs, 4 A sbe, 5 A dbe, 6 B sbe, 7 B dbe, 8 cache
  task automatic pulse(input logic [8:0] ev, input int exp_st, input int exp_nmi,
                       input int exp_rst, input string tag);
    @(negedge clk);
    reg_addr = 2'd2;
    {cache_par_evt, ecc_dbe_evt[1], ecc_sbe_evt[1], ecc_dbe_evt[0], ecc_sbe_evt[0],
     hs_par_evt, bank_par_evt} = ev;
    @(posedge clk);
    #1;
    check({tag, " status"}, int'(reg_rdata), exp_st);
    check({tag, " nmi"}, int'(nmi_o), exp_nmi);
    check({tag, " rst"}, int'(rst_req_o), exp_rst);
    @(negedge clk);
    {cache_par_evt, ecc_dbe_evt[1], ecc_sbe_evt[1], ecc_dbe_evt[0], ecc_sbe_evt[0],
     hs_par_evt, bank_par_evt} = '0;
    @(posedge clk);
    #1 check({tag, " rst one cycle R8"}, int'(rst_req_o), 0);
  endtask

  initial begin
    #(PERIOD * 200000);
    n_bad++;
    $display("FAIL watchdog expired");
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    rd_check(2'd0, 0, "R1 lock");
    rd_check(2'd1, 0, "R1 cfg");
    rd_check(2'd2, 0, "R1 status");
    check("R1 nmi", int'(nmi_o), 0);
    check("R1 rst", int'(rst_req_o), 0);

    // R2 / R3 key protection
    wr(2'd1, 16'h007F);
    rd_check(2'd1, 0, "R3 locked write ignored");
    wr(2'd0, 16'h1077);
    rd_check(2'd0, 0, "R2 wrong upper key");
    wr(2'd0, 16'h0077);
    rd_check(2'd0, 1, "R2 unlock");
    wr(2'd1, 16'h0055);
    rd_check(2'd1, 16'h55, "R3 unlocked write");
    wr(2'd0, 16'h0012);
    rd_check(2'd0, 0, "R2 relock");
    wr(2'd1, 16'h002A);
    rd_check(2'd1, 16'h55, "R3 relocked write ignored");
    wr(2'd0, 16'h0077);

    // R5 R6 R7 R8 sweep over ECC regions, modes, selects, error kinds
    for (int r = 0; r < 2; r++)
      for (int m = 0; m < 4; m++)
        for (int s = 0; s < 2; s++)
          for (int k = 0; k < 2; k++) begin
            int flag, resp, pos;
            pos  = 4 + 2*r + k;
            flag = (k == 1) ? int'(m != 0) : int'(m >= 2);
            resp = (k == 1) ? int'(m != 0) : int'(m == 3);
            wr(2'd1, 16'(m << (2*r)) | 16'(s << (5+r)));
            wr(2'd2, 16'h01FF);
            pulse(9'(1 << pos), flag << pos, resp & (s == 0 ? 1 : 0),
                  resp & s, $sformatf("R5/R6/R7 r%0d m%0d s%0d k%0d", r, m, s, k));
          end

    // R4 R8 parity sweep over banks and high-speed RAM, both selects
    for (int b = 0; b < 4; b++)
      for (int s = 0; s < 2; s++) begin
        wr(2'd1, 16'(s << 4));
        wr(2'd2, 16'h01FF);
        pulse(9'(1 << b), 1 << b, 1 - s, s, $sformatf("R4 bank%0d s%0d", b, s));
      end
    for (int s = 0; s < 2; s++) begin
      wr(2'd1, 16'(s << 4) | 16'h0060);
      wr(2'd2, 16'h01FF);
      pulse(9'h100, 9'h100, 0, 0, $sformatf("R4 cache s%0d", s));
    end

    // R9 NMI level held across partial clear
    wr(2'd1, 16'h0000);
    wr(2'd2, 16'h01FF);
    pulse(9'h001, 1, 1, 0, "R9 first flag");
    pulse(9'h002, 3, 1, 0, "R9 second flag");
    wr(2'd2, 16'h0001);
    rd_check(2'd2, 2, "R10 partial clear");
    check("R9 nmi held", int'(nmi_o), 1);
    wr(2'd2, 16'h0000);
    rd_check(2'd2, 2, "R10 zero write keeps");
    wr(2'd2, 16'h0002);
    rd_check(2'd2, 0, "R10 full clear");
    check("R9 nmi drops", int'(nmi_o), 0);
    // R9 single-bit flag counts only in mode 3
    wr(2'd1, 16'h0003);
    pulse(9'h010, 9'h010, 1, 0, "R9 sbe mode3");
    wr(2'd1, 16'h0002);
    #1 check("R9 sbe mode2 no nmi", int'(nmi_o), 0);
    wr(2'd2, 16'h01FF);

    // R11 event versus clear in same cycle
    pulse(9'h004, 4, 1, 0, "R11 prep");
    wr(2'd2, 16'h0004, 9'h004);
    rd_check(2'd2, 4, "R11 event wins");
    wr(2'd2, 16'h0004);
    rd_check(2'd2, 0, "R11 clear alone");

    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end

endmodule